// File: doc/BRIEF.md
# Interrupt Status, Enable and Clear Unit

This block collects the event and level conditions of a storage-bus host controller into one 8-bit status view. Some status bits are live copies of their sources. Others are sticky flags that hold a FIFO fault until software clears it. An enable register masks the status view and produces two separate registered requests. The first is a CPU interrupt for the FIFO faults, the engine-idle condition and the device interrupt copy. The second is a DMA end-of-transfer request, raised when the device interrupt line is asserted and its enable bit is set.

Software reaches the unit through a plain register port. A 2-bit selector picks the status view, the enable register or the clear register. Writes take effect on the rising clock edge. Read data is combinational from the selector. There is no streaming data path, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `intr_ctrl`

## Requirements
- R1: Status bits 7 and 3 both show the current level of `dev_irq`, including while `rst_n` is low. They read 0 when the line is low and 1 when it is high.
- R2: Status bit 4 reads 1 while `eng_idle` is high and 0 while it is low.
- R3: A one-cycle `fifo_under` pulse sets status bit 6, and the bit stays 1 after the pulse ends. Writing the clear register (`reg_sel`=2) with bit 6 of the data at 1 returns it to 0.
- R4: A one-cycle `fifo_over` pulse sets status bit 5, and the bit stays 1 after the pulse ends. Writing the clear register with bit 5 of the data at 1 returns it to 0.
- R5: Clear-register writes leave status bits 7, 4 and 3 unchanged. A clear-register write leaves any sticky bit whose data bit is 0 unchanged.
- R6: When a sticky event pulse and a clear of the same bit arrive in the same cycle, the bit ends that cycle at 1.
- R7: The enable register (`reg_sel`=1) resets to 0x00 and reads back what was written. Its bits 2 to 0 always read 0.
- R8: Writes with `reg_sel`=0 (status) change neither the status view nor the enable register.
- R9: `cpu_irq` is 1 one cycle after any of status bits 6, 5, 4 or 3 is 1 together with the same enable bit. Otherwise it is 0, and it resets to 0.
- R10: `dma_req` is 1 one cycle after status bit 7 and enable bit 7 are both 1. Enable bit 7 alone never raises `cpu_irq`.
- R11: Reads with `reg_sel`=2 (clear) or `reg_sel`=3 (unused) return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_irq | input | 1 | Device interrupt line, synchronous level |
| fifo_under | input | 1 | FIFO underflow event pulse |
| fifo_over | input | 1 | FIFO overflow event pulse |
| eng_idle | input | 1 | Protocol engine idle level |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 status, 1 enable, 2 clear, 3 unused |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| cpu_irq | output | 1 | Registered CPU interrupt request |
| dma_req | output | 1 | Registered DMA end-of-transfer request |

## Verification
The live bits are driven both high and low, including while reset is held, so that a live copy can be told apart from a registered or reset-forced bit. The sticky bits are tested with an isolated pulse, with a clear of the other bit only, and with a pulse that coincides with its own clear, which separates correct set/clear priority from a simple toggle or a clear-wins design. The enable masks are set to a single bit at a time, either bit 7 or a CPU bit. This shows that each source reaches only its own request output, and it also confirms the one-cycle output latency.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int REG_W   = 8;
  localparam int SEL_W   = 2;
  localparam int N_STICK = 2;

  // Bit positions are the software-visible layout
  localparam int B_DMA   = 7;
  localparam int B_UNDER = 6;
  localparam int B_OVER  = 5;
  localparam int B_IDLE  = 4;
  localparam int B_DEV   = 3;

  localparam logic [REG_W-1:0] EN_MASK  = 8'hF8;
  localparam logic [REG_W-1:0] CPU_MASK = 8'h78;

  typedef enum logic [SEL_W-1:0] {
    SEL_STAT = 2'd0,
    SEL_EN   = 2'd1,
    SEL_CLR  = 2'd2,
    SEL_RSV  = 2'd3
  } sel_e;
endpackage

// File: rtl/intr_sticky.sv
module intr_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (evt[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end

    // R6: a new event beats a simultaneous clear
    a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> q[i]);
    // R3: a clear without an event empties the flag
    a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !evt[i]) |=> !q[i]);
    // R3: the flag holds without a clear
    a_r3_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] && !clr[i]) |=> q[i]);
  end
endmodule

// File: rtl/intr_enable.sv
module intr_enable
  import intr_pkg::*;
#(
  parameter int W = REG_W,
  parameter logic [W-1:0] MASK = EN_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en <= '0;
    else if (wr) en <= wdata & MASK;
  end

  // R7: a write lands, with unused bits forced low
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> en == ($past(wdata) & MASK));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(en));
endmodule

// File: rtl/intr_req_gen.sv
module intr_req_gen
  import intr_pkg::*;
#(
  parameter int W = REG_W,
  parameter logic [W-1:0] CPU_BITS = CPU_MASK,
  parameter int DMA_BIT = B_DMA
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat,
  input  logic [W-1:0] en,
  output logic         cpu_irq,
  output logic         dma_req
);
  logic [W-1:0] hit;
  assign hit = stat & en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_irq <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      cpu_irq <= |(hit & CPU_BITS);
      dma_req <= hit[DMA_BIT];
    end
  end

  // R10: the DMA request tracks bit 7 with one cycle of latency
  a_r10_dma_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[DMA_BIT] && en[DMA_BIT]) |=> dma_req);
  // R10: enable bit 7 alone cannot wake the CPU
  a_r10_no_cpu_from_dma: assert property (@(posedge clk) disable iff (!rst_n)
    ((en & CPU_BITS) == '0) |=> !cpu_irq);
  // R9: any enabled CPU source raises the interrupt
  a_r9_cpu_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & en & CPU_BITS) != '0) |=> cpu_irq);
endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_irq,
  input  logic             fifo_under,
  input  logic             fifo_over,
  input  logic             eng_idle,
  input  logic             reg_wr,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             cpu_irq,
  output logic             dma_req
);
  logic [N_STICK-1:0] stick_evt, stick_clr, stick_q;
  logic [REG_W-1:0]   en, stat;
  logic               wr_en, wr_clr;

  assign wr_en  = reg_wr && (sel_e'(reg_sel) == SEL_EN);
  assign wr_clr = reg_wr && (sel_e'(reg_sel) == SEL_CLR);

  // sticky index 1 = underflow, 0 = overflow
  assign stick_evt = {fifo_under, fifo_over};
  assign stick_clr = {wr_clr & reg_wdata[B_UNDER], wr_clr & reg_wdata[B_OVER]};

  intr_sticky #(.N(N_STICK)) u_sticky (
    .clk(clk), .rst_n(rst_n), .evt(stick_evt), .clr(stick_clr), .q(stick_q)
  );

  intr_enable #(.W(REG_W), .MASK(EN_MASK)) u_enable (
    .clk(clk), .rst_n(rst_n), .wr(wr_en), .wdata(reg_wdata), .en(en)
  );

  always_comb begin
    stat          = '0;
    stat[B_DMA]   = dev_irq;
    stat[B_UNDER] = stick_q[1];
    stat[B_OVER]  = stick_q[0];
    stat[B_IDLE]  = eng_idle;
    stat[B_DEV]   = dev_irq;
  end

  always_comb begin
    unique case (sel_e'(reg_sel))
      SEL_STAT: reg_rdata = stat;
      SEL_EN:   reg_rdata = en;
      default:  reg_rdata = '0;
    endcase
  end

  intr_req_gen #(.W(REG_W), .CPU_BITS(CPU_MASK), .DMA_BIT(B_DMA)) u_req (
    .clk(clk), .rst_n(rst_n), .stat(stat), .en(en),
    .cpu_irq(cpu_irq), .dma_req(dma_req)
  );

  // R8: a status write leaves the enable register alone
  a_r8_stat_wr_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0) |=> $stable(en));
  // R5: a clear write never disturbs the enables
  a_r5_clr_keeps_en: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> $stable(en));
endmodule

// File: tb/intr_ctrl_tb.sv
module intr_ctrl_tb_top;
  logic       clk = 0, rst_n = 0;
  logic       dev_irq = 0, fifo_under = 0, fifo_over = 0, eng_idle = 0;
  logic       reg_wr = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic       cpu_irq, dma_req;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intr_ctrl dut_i (.*);

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(logic [1:0] s, output logic [7:0] d);
    reg_sel = s; #1; d = reg_rdata;
  endtask

  task automatic pulse_under();
    @(negedge clk); fifo_under = 1; @(negedge clk); fifo_under = 0;
  endtask

  task automatic pulse_over();
    @(negedge clk); fifo_over = 1; @(negedge clk); fifo_over = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    dev_irq = 1; #2; rd(0, d);
    chk("R1", "bit7/bit3 high in reset", d & 8'h88, 8'h88);
    dev_irq = 0; #2; rd(0, d);
    chk("R1", "bit7/bit3 low in reset", d & 8'h88, 8'h00);
    repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
    rd(1, d); chk("R7", "enable reset", d, 8'h00);
    chk("R9", "cpu_irq reset", {7'b0, cpu_irq}, 8'h00);
  endtask

  task automatic t_live();
    logic [7:0] d;
    @(negedge clk); dev_irq = 1; eng_idle = 0; rd(0, d);
    chk("R1", "live high", d, 8'h88);
    eng_idle = 1; dev_irq = 0; rd(0, d);
    chk("R2", "idle high", d, 8'h10);
    eng_idle = 0; rd(0, d);
    chk("R2", "idle low", d, 8'h00);
  endtask

  task automatic t_sticky();
    logic [7:0] d;
    pulse_under(); @(negedge clk); rd(0, d);
    chk("R3", "underflow held", d, 8'h40);
    pulse_over(); @(negedge clk); rd(0, d);
    chk("R4", "overflow held", d, 8'h60);
    wr(2, 8'h40); rd(0, d);
    chk("R5", "clear bit6 keeps bit5", d, 8'h20);
    chk("R3", "bit6 cleared", d & 8'h40, 8'h00);
    wr(2, 8'h20); rd(0, d);
    chk("R4", "bit5 cleared", d, 8'h00);
  endtask

  task automatic t_clear_live();
    logic [7:0] d;
    @(negedge clk); dev_irq = 1; eng_idle = 1;
    wr(2, 8'hFF); rd(0, d);
    chk("R5", "clear ignores live bits", d, 8'h98);
    dev_irq = 0; eng_idle = 0;
  endtask

  task automatic t_collide();
    logic [7:0] d;
    @(negedge clk); reg_wr = 1; reg_sel = 2; reg_wdata = 8'h60;
    fifo_under = 1; fifo_over = 1;
    @(negedge clk); reg_wr = 0; fifo_under = 0; fifo_over = 0; rd(0, d);
    chk("R6", "event beats clear", d, 8'h60);
    wr(2, 8'h60);
  endtask

  task automatic t_enable();
    logic [7:0] d;
    wr(1, 8'hFF); rd(1, d);
    chk("R7", "enable low bits zero", d, 8'hF8);
    wr(1, 8'h50); rd(1, d);
    chk("R7", "enable readback", d, 8'h50);
  endtask

  task automatic t_stat_write();
    logic [7:0] d;
    pulse_under();
    wr(0, 8'h00); rd(0, d);
    chk("R8", "status write ignored", d, 8'h40);
    rd(1, d);
    chk("R8", "enable untouched", d, 8'h50);
  endtask

  task automatic t_irq();
    wr(1, 8'h40); @(negedge clk);
    chk("R9", "irq from underflow", {7'b0, cpu_irq}, 8'h01);
    wr(2, 8'h40); @(negedge clk);
    chk("R9", "irq drops on clear", {7'b0, cpu_irq}, 8'h00);
    wr(1, 8'h08); @(negedge clk); dev_irq = 1; @(negedge clk);
    chk("R9", "irq from bit3", {7'b0, cpu_irq}, 8'h01);
    chk("R10", "no dma when bit7 masked", {7'b0, dma_req}, 8'h00);
    dev_irq = 0; @(negedge clk);
  endtask

  task automatic t_dma();
    wr(1, 8'h80); @(negedge clk); dev_irq = 1; @(negedge clk);
    chk("R10", "dma raised", {7'b0, dma_req}, 8'h01);
    chk("R10", "no cpu irq from bit7", {7'b0, cpu_irq}, 8'h00);
    dev_irq = 0; @(negedge clk);
    chk("R10", "dma dropped", {7'b0, dma_req}, 8'h00);
  endtask

  task automatic t_map();
    logic [7:0] d;
    @(negedge clk); dev_irq = 1; eng_idle = 1;
    rd(2, d); chk("R11", "clear reads zero", d, 8'h00);
    rd(3, d); chk("R11", "unused reads zero", d, 8'h00);
    dev_irq = 0; eng_idle = 0;
  endtask

  initial begin
    t_reset(); t_live(); t_sticky(); t_clear_live(); t_collide();
    t_enable(); t_stat_write(); t_irq(); t_dma(); t_map();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule